// File: doc/BRIEF.md
# Long-Word Cache Entry Fill Sequencer

This block fills one 32-bit cache entry from an external bus whose responding device may be 8, 16 or 32 bits wide. The width is not known in advance: the device reports it with every cycle termination. After a fill request the sequencer runs as many bus cycles as it needs to collect all four bytes of the aligned long word. It steers each returned chunk into the byte lanes that match its address. Then it either writes the entry into the cache or, if the cache-inhibit input was seen on any of those cycles, leaves the entry uncached.

The requester always receives the assembled long word with a one-clock done pulse, whether or not it was cached. Each bus cycle asks only for the bytes still missing, starting at the next uncollected address. A device that terminates wider than requested is taken to have delivered every byte of its port group.

Top module: `lwf_fill_seq`

## Requirements
- R1: After synchronous reset, bus_req, fill_done and cw_en are all low.
- R2: A fill_req seen while idle is accepted at that clock edge. In the next cycle bus_req is high, bus_addr is the request address with its two low bits cleared, and bus_size is 00. Size encoding: 00 means 4 bytes; 01, 10 and 11 mean 1, 2 and 3 bytes.
- R3: While bus_req is high and bus_term is 00 (no termination), bus_req, bus_addr and bus_size stay unchanged.
- R4: Termination codes are 01 for an 8-bit port, 10 for a 16-bit port and 11 for a 32-bit port. After a termination at byte offset k with a port of P bytes, the next offset is (k OR (P-1)) + 1. If that value is below 4, the next cycle keeps bus_req high, puts the same long-word address with that offset on bus_addr, and requests the remaining 4 minus offset bytes.
- R5: Byte k of the long word (big-endian, bits [31-8k : 24-8k]) is taken from port lane k mod P. Lane l of the port is bus_rdata[31-8l : 24-8l]. An 8-bit port therefore uses [31:24] and a 16-bit port uses [31:16].
- R6: A 32-bit termination makes every remaining byte valid at once. A 16-bit termination makes both bytes of its halfword valid, even when fewer bytes were requested.
- R7: In the cycle after the termination that completes byte 3, bus_req is low and fill_done is high for exactly one cycle, with fill_data holding the assembled long word.
- R8: cw_en pulses together with fill_done only if bus_inhibit was low on every termination of the entry. When it pulses, cw_addr is the aligned address and cw_data is the assembled word. fill_cached shows the same decision.
- R9: If bus_inhibit was high on any termination of the entry, cw_en stays low and fill_cached is low, but fill_data still carries the assembled word.
- R10: fill_req is ignored while a fill is in progress or while fill_done is high. The bus address does not change and no further fill starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_req | input | 1 | Start a fill (taken only when idle) |
| fill_addr | input | ADDR_W | Address of the entry to fill |
| fill_done | output | 1 | One-cycle completion pulse |
| fill_data | output | 32 | Assembled long word |
| fill_cached | output | 1 | Entry was written into the cache |
| bus_req | output | 1 | Bus cycle request, held until termination |
| bus_addr | output | ADDR_W | Byte address of the current bus cycle |
| bus_size | output | 2 | Bytes requested (00 = 4) |
| bus_term | input | 2 | Termination: 00 none, 01 8-bit, 10 16-bit, 11 32-bit |
| bus_inhibit | input | 1 | Cache inhibit, sampled with the termination |
| bus_rdata | input | 32 | Returned data, port lanes top-justified |
| cw_en | output | 1 | Cache entry write strobe |
| cw_addr | output | ADDR_W | Aligned entry address for the write |
| cw_data | output | 32 | Long word for the write |

## Verification
The first bus cycle appears one clock after fill_req is accepted. Each later bus address and size, or the done pulse with the cache write, appears one clock after the terminating edge. The done pulse falls one clock after that. The bench drives every input on the falling edge and checks the outputs on the falling edge that follows the relevant rising edge, so each check sees exactly one register update. It sweeps every sequence of port widths across the termination cycles, with inserted wait cycles and inhibit placed on each cycle in turn.

// File: rtl/lwf_pkg.sv
package lwf_pkg;

    localparam int LW_BYTES = 4;
    localparam int LW_BITS  = 8 * LW_BYTES;
    localparam int OFF_W    = $clog2(LW_BYTES);

    typedef enum logic [1:0] {
        TERM_NONE = 2'b00,
        TERM_8    = 2'b01,
        TERM_16   = 2'b10,
        TERM_32   = 2'b11
    } term_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_BUS  = 2'b01,
        ST_DONE = 2'b10
    } state_e;

    typedef struct packed {
        logic [LW_BITS-1:0] data;
        logic [OFF_W-1:0]   offset;
        logic               inhibited;
    } fill_ctx_t;

    // port bytes minus one, used as a byte-offset mask
    function automatic logic [OFF_W-1:0] port_mask(input term_e t);
        case (t)
            TERM_16: port_mask = 2'd1;
            TERM_32: port_mask = 2'd3;
            default: port_mask = 2'd0;
        endcase
    endfunction

    // pick a byte lane from the top-justified port data
    function automatic logic [7:0] lane_byte(input logic [LW_BITS-1:0] d,
                                             input logic [OFF_W-1:0] lane);
        case (lane)
            2'd0:    lane_byte = d[31:24];
            2'd1:    lane_byte = d[23:16];
            2'd2:    lane_byte = d[15:8];
            default: lane_byte = d[7:0];
        endcase
    endfunction

endpackage

// File: rtl/lwf_lane_merge.sv
module lwf_lane_merge
    import lwf_pkg::*;
(
    input  logic [LW_BITS-1:0] cur_data,
    input  logic [OFF_W-1:0]   offset,
    input  term_e              term,
    input  logic [LW_BITS-1:0] rdata,
    output logic [LW_BITS-1:0] next_data,
    output logic [OFF_W:0]     next_offset
);

    logic [OFF_W-1:0] mask;
    logic [OFF_W-1:0] last_byte;

    assign mask        = port_mask(term);
    assign last_byte   = offset | mask;
    assign next_offset = {1'b0, last_byte} + 1'b1;

    for (genvar j = 0; j < LW_BYTES; j++) begin : g_byte
        localparam logic [OFF_W-1:0] IDX = OFF_W'(j);
        logic [OFF_W-1:0] lane;
        logic             take;
        assign lane = IDX & mask;
        assign take = (IDX >= offset) && (IDX <= last_byte);
        assign next_data[LW_BITS-1-8*j -: 8] =
            take ? lane_byte(rdata, lane) : cur_data[LW_BITS-1-8*j -: 8];
    end

endmodule

// File: rtl/lwf_ctrl.sv
module lwf_ctrl
    import lwf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   beat,
    input  logic   last,
    output state_e state
);

    state_e state_n;

    always_comb begin
        state_n = state;
        case (state)
            ST_IDLE: if (start)        state_n = ST_BUS;
            ST_BUS:  if (beat && last) state_n = ST_DONE;
            ST_DONE:                   state_n = ST_IDLE;
            default:                   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_n;
    end

endmodule

// File: rtl/lwf_fill_seq.sv
module lwf_fill_seq
    import lwf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_req,
    input  logic [ADDR_W-1:0] fill_addr,
    output logic              fill_done,
    output logic [31:0]       fill_data,
    output logic              fill_cached,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    input  logic [1:0]        bus_term,
    input  logic              bus_inhibit,
    input  logic [31:0]       bus_rdata,
    output logic              cw_en,
    output logic [ADDR_W-1:0] cw_addr,
    output logic [31:0]       cw_data
);

    localparam int TAG_W = ADDR_W - OFF_W;

    state_e             state;
    fill_ctx_t          ctx;
    logic [TAG_W-1:0]   tag;
    term_e              term;
    logic               beat;
    logic [LW_BITS-1:0] merged;
    logic [OFF_W:0]     off_next;
    logic               accept;

    assign term   = term_e'(bus_term);
    assign beat   = (state == ST_BUS) && (term != TERM_NONE);
    assign accept = (state == ST_IDLE) && fill_req;

    lwf_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (fill_req),
        .beat  (beat),
        .last  (off_next[OFF_W]),
        .state (state)
    );

    lwf_lane_merge u_merge (
        .cur_data    (ctx.data),
        .offset      (ctx.offset),
        .term        (term),
        .rdata       (bus_rdata),
        .next_data   (merged),
        .next_offset (off_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx <= '0;
            tag <= '0;
        end else if (accept) begin
            ctx <= '0;
            tag <= fill_addr[ADDR_W-1:OFF_W];
        end else if (beat) begin
            ctx.data      <= merged;
            ctx.offset    <= off_next[OFF_W-1:0];
            ctx.inhibited <= ctx.inhibited | bus_inhibit;
        end
    end

    assign bus_req     = (state == ST_BUS);
    assign bus_addr    = {tag, ctx.offset};
    assign bus_size    = OFF_W'(0) - ctx.offset;
    assign fill_done   = (state == ST_DONE);
    assign fill_data   = ctx.data;
    assign fill_cached = !ctx.inhibited;
    assign cw_en       = fill_done && !ctx.inhibited;
    assign cw_addr     = {tag, {OFF_W{1'b0}}};
    assign cw_data     = ctx.data;

endmodule

// File: rtl/lwf_fill_seq_chk.sv
module lwf_fill_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              fill_req,
    input logic              fill_done,
    input logic              fill_cached,
    input logic              bus_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic [1:0]        bus_term,
    input logic              cw_en,
    input logic [ADDR_W-1:0] cw_addr
);

    logic [2:0] remain;
    assign remain = (bus_size == 2'b00) ? 3'd4 : {1'b0, bus_size};

    assert_start_R2: assert property (@(posedge clk) disable iff (rst)
        fill_req && !bus_req && !fill_done |=>
            bus_req && bus_addr[1:0] == 2'b00 && bus_size == 2'b00);

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_term == 2'b00 |=>
            bus_req && $stable(bus_addr) && $stable(bus_size));

    assert_size_R4: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> ({1'b0, bus_addr[1:0]} + remain) == 3'd4);

    assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_term != 2'b00 |=>
            fill_done || (bus_req && bus_addr[1:0] > $past(bus_addr[1:0])));

    assert_byte_step_R4: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_term == 2'b01 |=>
            fill_done || bus_addr == $past(bus_addr) + 1'b1);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        fill_done |=> !fill_done && !bus_req);

    assert_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && fill_done));

    assert_write_gate_R8: assert property (@(posedge clk) disable iff (rst)
        cw_en |-> fill_done && fill_cached && cw_addr[1:0] == 2'b00);

    assert_inhibit_R9: assert property (@(posedge clk) disable iff (rst)
        fill_done && !fill_cached |-> !cw_en);

endmodule

bind lwf_fill_seq lwf_fill_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fill_req    (fill_req),
    .fill_done   (fill_done),
    .fill_cached (fill_cached),
    .bus_req     (bus_req),
    .bus_addr    (bus_addr),
    .bus_size    (bus_size),
    .bus_term    (bus_term),
    .cw_en       (cw_en),
    .cw_addr     (cw_addr)
);

// File: tb/lwf_fill_seq_tb.sv
`timescale 1ns/1ps
module lwf_fill_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fill_req = 1'b0;
    logic [31:0] fill_addr = '0;
    logic        fill_done;
    logic [31:0] fill_data;
    logic        fill_cached;
    logic        bus_req;
    logic [31:0] bus_addr;
    logic [1:0]  bus_size;
    logic [1:0]  bus_term = 2'b00;
    logic        bus_inhibit = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        cw_en;
    logic [31:0] cw_addr;
    logic [31:0] cw_data;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    lwf_fill_seq #(.ADDR_W(32)) u_dut (
        .clk(clk), .rst(rst),
        .fill_req(fill_req), .fill_addr(fill_addr),
        .fill_done(fill_done), .fill_data(fill_data), .fill_cached(fill_cached),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_term(bus_term), .bus_inhibit(bus_inhibit), .bus_rdata(bus_rdata),
        .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [31:0] a, input logic [7:0] seed);
        return 8'((a * 13) ^ (a >> 3)) ^ seed;
    endfunction

    // bus model: port of pb bytes drives its aligned group top-justified
    function automatic logic [31:0] bus_word(input logic [31:0] a, input int pb,
                                             input logic [7:0] seed);
        logic [31:0] w = 32'hA5C3_5A3C;
        logic [31:0] grp = a & ~(32'(pb) - 1);
        for (int l = 0; l < pb; l++) w[31-8*l -: 8] = mem_byte(grp + 32'(l), seed);
        return w;
    endfunction

    task automatic run_fill(input int p);
        logic [31:0] base = 32'h0000_4000 + 32'(p) * 16;
        logic [7:0]  seed = 8'(p * 7 + 3);
        logic [31:0] exp_data;
        int inh_at = p % 5;
        bit inh_acc = 0;
        int off = 0;
        int i = 0;
        int div = 1;
        exp_data = {mem_byte(base, seed), mem_byte(base + 1, seed),
                    mem_byte(base + 2, seed), mem_byte(base + 3, seed)};
        @(negedge clk);
        fill_req = 1'b1;
        fill_addr = base | 32'(p % 4);
        @(negedge clk);
        fill_req = 1'b0;
        chk(bus_req && bus_addr == base && bus_size == 2'b00, "R2", bus_addr, base);
        while (off < 4) begin
            int d = (p / div) % 3;
            int pb = 1 << d;
            logic [1:0] exp_size = 2'(4 - off);
            if ((p + i) % 3 == 0) begin
                fill_req = 1'b1;
                fill_addr = base + 32'h100;
                bus_term = 2'b00;
                @(negedge clk);
                fill_req = 1'b0;
                chk(bus_req && bus_addr == base + 32'(off) && bus_size == exp_size,
                    "R3 R10", bus_addr, base + 32'(off));
            end
            bus_term = 2'(d + 1);
            bus_rdata = bus_word(base + 32'(off), pb, seed);
            bus_inhibit = (i == inh_at);
            @(negedge clk);
            bus_term = 2'b00;
            bus_inhibit = 1'b0;
            bus_rdata = 32'hDEAD_BEEF;
            inh_acc = inh_acc | (i == inh_at);
            off = (off | (pb - 1)) + 1;
            i++;
            div = div * 3;
            if (off < 4) begin
                chk(bus_req && !fill_done && bus_addr == base + 32'(off),
                    "R4 addr", bus_addr, base + 32'(off));
                chk(bus_size == 2'(4 - off), "R4 size", 32'(bus_size), 32'(4 - off));
            end else begin
                chk(fill_done && !bus_req, "R7 done", {30'b0, fill_done, bus_req}, 32'h2);
                chk(fill_data == exp_data, d > 0 ? "R6 data" : "R5 data",
                    fill_data, exp_data);
                chk(cw_en == !inh_acc && fill_cached == !inh_acc,
                    inh_acc ? "R9" : "R8", {30'b0, cw_en, fill_cached},
                    {30'b0, !inh_acc, !inh_acc});
                if (!inh_acc)
                    chk(cw_addr == base && cw_data == exp_data, "R8 write", cw_data, exp_data);
                fill_req = 1'b1;
                fill_addr = base + 32'h200;
                @(negedge clk);
                fill_req = 1'b0;
                chk(!fill_done && !bus_req && !cw_en, "R7 R10 idle",
                    {29'b0, fill_done, bus_req, cw_en}, 32'h0);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!bus_req && !fill_done && !cw_en, "R1 reset",
            {29'b0, bus_req, fill_done, cw_en}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(!bus_req && !fill_done && !cw_en, "R1 after reset",
            {29'b0, bus_req, fill_done, cw_en}, 32'h0);
        for (int p = 0; p < 81; p++) run_fill(p);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule